// File: doc/BRIEF.md
# Return-to-Zero Handshake Link Between Two Clock Domains

This block carries parallel words from a sending unit to a receiving unit when each runs on its own clock, and the two clocks have no fixed phase or frequency relationship. A shared data bus and two control wires join the sides. The sender drives a "word present" wire. The receiver drives a "word taken" wire. Every transfer is a complete four-step exchange in which both wires go high and then return low, so each side always knows the state of the other.

On the sending side, words enter through a local ready/valid port. The sender stores the word in a holding register and drives it onto the bus. It raises "word present" one clock later. It then waits for "word taken" to go high, drops "word present", and waits for "word taken" to go low before it can accept another word. On the receiving side, a raised "word present" causes the word to be captured. "Word taken" is raised at the same moment, and the captured word is announced with a one-cycle strobe. When "word present" falls, "word taken" is released. Each side passes the other's control wire through a two-flop synchronizer before using it.

Top module: `rtz_handshake_link`

## Requirements
- R1: During and right after reset, `lnk_valid`, `lnk_accept` and `dst_out_strobe` are 0, and `src_in_ready` is 1.
- R2: A word is taken on a `src_clk` edge where `src_in_valid` and `src_in_ready` are both 1. After that edge, `lnk_data` holds the word, `lnk_valid` is still 0 and `src_in_ready` is 0. On the next `src_clk` edge, `lnk_valid` goes to 1.
- R3: `lnk_data` does not change from the cycle before `lnk_valid` rises until `lnk_valid` falls, whatever happens on `src_in_data`.
- R4: The receiver raises `lnk_accept` only after it has seen `lnk_valid` high through its synchronizer. On that same `dst_clk` edge it captures the bus into `dst_out_data` and pulses `dst_out_strobe` high for exactly one `dst_clk` cycle.
- R5: `lnk_valid` stays high until the synchronized `lnk_accept` is seen high. It then falls within four `src_clk` cycles of `lnk_accept` being observed high.
- R6: `lnk_accept` stays high until the synchronized `lnk_valid` is seen low. It then falls within four `dst_clk` cycles of `lnk_valid` going low.
- R7: `src_in_ready` stays 0 from the moment a word is taken until the synchronized `lnk_accept` has been seen low again. It is never 1 while `lnk_valid` is 1.
- R8: Every word taken at the source is delivered exactly once, in order and unaltered, for receiver clocks both faster and slower than the sender clock.
- R9: `src_in_valid` pulses while `src_in_ready` is 0 are ignored: they produce no extra delivered word and do not change the word in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Sending side clock |
| src_rst_n | input | 1 | Sending side synchronous reset, active low |
| src_in_valid | input | 1 | Local word offered to the sender |
| src_in_data | input | WIDTH | Local word value |
| src_in_ready | output | 1 | Sender can take a word this cycle |
| dst_clk | input | 1 | Receiving side clock |
| dst_rst_n | input | 1 | Receiving side synchronous reset, active low |
| dst_out_strobe | output | 1 | One-cycle pulse marking a delivered word |
| dst_out_data | output | WIDTH | Last delivered word |
| lnk_valid | output | 1 | Word-present wire driven by the sender |
| lnk_accept | output | 1 | Word-taken wire driven by the receiver |
| lnk_data | output | WIDTH | Shared data bus driven by the sender |

## Verification
The bench sends words under four receiver clock periods, some faster and some slower than the sender clock. A receiver that sampled the bus without the synchronized valid, or strobed for more than one cycle, would show duplicated or wrong words in the received sequence. While a word is in flight, the bench pulses the local input with a different value. A sender that took that pulse, or let the bus follow the input, would deliver an extra word or a corrupted one. The bench also measures how long each wire takes to fall after the other wire changes, and checks that the ready signal returns only after the accept wire is low. A sender that reopened early or skipped the release phase would fail these timing checks.

// File: rtl/hs_link_pkg.sv
// Shared state encodings for the two sides of the return-to-zero link.
package hs_link_pkg;
    typedef enum logic [1:0] {
        SRC_IDLE,      // free, may take a local word
        SRC_SETUP,     // bus driven, valid not yet raised
        SRC_WAIT_ACC,  // valid high, waiting for accept
        SRC_WAIT_REL   // valid low, waiting for accept to drop
    } src_state_t;

    typedef enum logic {
        DST_IDLE,      // waiting for valid
        DST_HOLD       // accept high, waiting for valid to drop
    } dst_state_t;
endpackage

// File: rtl/hs_sync.sv
// Multi-flop synchronizer for one control wire.
// Assumes the input is a level that stays put for several destination cycles.
module hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            // one flop per stage, stage 0 samples the async input
            always_ff @(posedge clk) begin
                if (!rst_n)      chain[i] <= 1'b0;
                else if (i == 0) chain[i] <= d;
                else             chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_src_ctrl.sv
// Sending side controller: takes a word from the local ready/valid port, holds
// it on the bus, raises valid a cycle later, and runs the four-phase exchange.
// Assumes acc_sync is already synchronized to clk.
module hs_src_ctrl
    import hs_link_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic             in_ready,
    input  logic             acc_sync,
    output logic             bus_valid,
    output logic [WIDTH-1:0] bus_data
);
    src_state_t       state;
    logic [WIDTH-1:0] hold_q;
    logic             valid_q;

    // local port is open only in the idle state
    assign in_ready = (state == SRC_IDLE);

    // state walk through the exchange
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SRC_IDLE;
            valid_q <= 1'b0;
        end else begin
            case (state)
                SRC_IDLE:     if (in_valid) state <= SRC_SETUP;
                SRC_SETUP: begin
                    valid_q <= 1'b1;
                    state   <= SRC_WAIT_ACC;
                end
                SRC_WAIT_ACC: if (acc_sync) begin
                    valid_q <= 1'b0;
                    state   <= SRC_WAIT_REL;
                end
                SRC_WAIT_REL: if (!acc_sync) state <= SRC_IDLE;
                default:      state <= SRC_IDLE;
            endcase
        end
    end

    // holding register, loaded only when a local word is taken
    always_ff @(posedge clk) begin
        if (!rst_n)                               hold_q <= '0;
        else if (state == SRC_IDLE && in_valid)   hold_q <= in_data;
    end

    assign bus_valid = valid_q;
    assign bus_data  = hold_q;
endmodule

// File: rtl/hs_dst_ctrl.sv
// Receiving side controller: captures the bus when synchronized valid is seen,
// raises accept, strobes the word out once, and releases accept when valid drops.
// Assumes val_sync is already synchronized to clk and the bus settled earlier.
module hs_dst_ctrl
    import hs_link_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             val_sync,
    input  logic [WIDTH-1:0] bus_data,
    output logic             bus_accept,
    output logic             out_strobe,
    output logic [WIDTH-1:0] out_data
);
    dst_state_t       state;
    logic             acc_q;
    logic             stb_q;
    logic [WIDTH-1:0] cap_q;

    // capture, acknowledge and release sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DST_IDLE;
            acc_q <= 1'b0;
            stb_q <= 1'b0;
            cap_q <= '0;
        end else begin
            stb_q <= 1'b0;
            case (state)
                DST_IDLE: if (val_sync) begin
                    cap_q <= bus_data;
                    acc_q <= 1'b1;
                    stb_q <= 1'b1;
                    state <= DST_HOLD;
                end
                DST_HOLD: if (!val_sync) begin
                    acc_q <= 1'b0;
                    state <= DST_IDLE;
                end
                default: state <= DST_IDLE;
            endcase
        end
    end

    assign bus_accept = acc_q;
    assign out_strobe = stb_q;
    assign out_data   = cap_q;
endmodule

// File: rtl/rtz_handshake_link.sv
// Top of the link: sender and receiver controllers with a synchronizer on each
// incoming control wire. The link wires are brought out for observation.
// Assumes each reset is released synchronously to its own clock.
module rtz_handshake_link #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             src_clk,
    input  logic             src_rst_n,
    input  logic             src_in_valid,
    input  logic [WIDTH-1:0] src_in_data,
    output logic             src_in_ready,
    input  logic             dst_clk,
    input  logic             dst_rst_n,
    output logic             dst_out_strobe,
    output logic [WIDTH-1:0] dst_out_data,
    output logic             lnk_valid,
    output logic             lnk_accept,
    output logic [WIDTH-1:0] lnk_data
);
    logic acc_in_src;
    logic val_in_dst;

    hs_sync #(.STAGES(SYNC_STAGES)) u_sync_acc (
        .clk(src_clk), .rst_n(src_rst_n), .d(lnk_accept), .q(acc_in_src)
    );

    hs_sync #(.STAGES(SYNC_STAGES)) u_sync_val (
        .clk(dst_clk), .rst_n(dst_rst_n), .d(lnk_valid), .q(val_in_dst)
    );

    hs_src_ctrl #(.WIDTH(WIDTH)) u_src (
        .clk(src_clk), .rst_n(src_rst_n),
        .in_valid(src_in_valid), .in_data(src_in_data), .in_ready(src_in_ready),
        .acc_sync(acc_in_src), .bus_valid(lnk_valid), .bus_data(lnk_data)
    );

    hs_dst_ctrl #(.WIDTH(WIDTH)) u_dst (
        .clk(dst_clk), .rst_n(dst_rst_n),
        .val_sync(val_in_dst), .bus_data(lnk_data), .bus_accept(lnk_accept),
        .out_strobe(dst_out_strobe), .out_data(dst_out_data)
    );
endmodule

// File: rtl/hs_link_checker.sv
// Protocol checker for the link, attached to the top by bind.
module hs_link_checker #(
    parameter int WIDTH = 8
) (
    input logic             src_clk,
    input logic             src_rst_n,
    input logic             dst_clk,
    input logic             dst_rst_n,
    input logic             src_in_ready,
    input logic             lnk_valid,
    input logic             lnk_accept,
    input logic [WIDTH-1:0] lnk_data,
    input logic             dst_out_strobe
);
    // bus held steady while valid stays high
    assert_bus_stable_R3: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (lnk_valid && $past(lnk_valid)) |-> $stable(lnk_data));

    // valid rises only on a bus that was already settled, port closed
    assert_setup_before_valid_R2: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        $rose(lnk_valid) |-> ($stable(lnk_data) && !src_in_ready));

    // port never open during a live transfer
    assert_no_ready_with_valid_R7: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        src_in_ready |-> !lnk_valid);

    // delivery strobe lasts a single cycle
    assert_single_strobe_R4: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_out_strobe |=> !dst_out_strobe);

    // accept rises together with the delivery strobe
    assert_accept_with_strobe_R4: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        $rose(lnk_accept) |-> dst_out_strobe);
endmodule

bind rtz_handshake_link hs_link_checker #(.WIDTH(WIDTH)) u_chk (
    .src_clk(src_clk), .src_rst_n(src_rst_n),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
    .src_in_ready(src_in_ready), .lnk_valid(lnk_valid),
    .lnk_accept(lnk_accept), .lnk_data(lnk_data),
    .dst_out_strobe(dst_out_strobe)
);

// File: tb/rtz_handshake_link_bench.sv
`timescale 1ns/1ps
module rtz_handshake_link_bench;
    localparam int WIDTH = 8;
    localparam int NVEC  = 8;
    localparam int WD_LIMIT = 150000;

    // each entry: {receiver speed index, word}
    localparam logic [15:0] VEC [NVEC] = '{
        16'h00_3C, 16'h01_A5, 16'h02_00, 16'h03_FF,
        16'h00_81, 16'h02_7E, 16'h01_12, 16'h03_C3
    };

    logic             src_clk = 1'b0;
    logic             dst_clk = 1'b0;
    logic             src_rst_n = 1'b0;
    logic             dst_rst_n = 1'b0;
    logic             src_in_valid = 1'b0;
    logic [WIDTH-1:0] src_in_data = '0;
    logic             src_in_ready;
    logic             dst_out_strobe;
    logic [WIDTH-1:0] dst_out_data;
    logic             lnk_valid;
    logic             lnk_accept;
    logic [WIDTH-1:0] lnk_data;

    real dst_half = 3.1;
    int  tests = 0;
    int  fails = 0;
    int  wd = 0;
    logic [WIDTH-1:0] rx [64];
    int  rx_cnt = 0;
    int  sent = 0;
    int  rel_cnt = 0;
    logic prev_stb = 1'b0;
    logic prev_acc = 1'b0;

    always #4 src_clk = ~src_clk;            // 125 MHz
    always #(dst_half) dst_clk = ~dst_clk;

    rtz_handshake_link #(.WIDTH(WIDTH)) u_rtz_handshake_link (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // watchdog over sender cycles
    always @(posedge src_clk) begin
        wd++;
        if (wd > WD_LIMIT) begin
            fails++;
            tests++;
            $display("FAIL watchdog R8 actual=%0d expected<%0d", wd, WD_LIMIT);
            summary();
            $finish;
        end
    end

    // receiver-side monitor: strobe width, accept relation, release timing
    always @(negedge dst_clk) begin
        if (dst_rst_n) begin
            if (dst_out_strobe) begin
                rx[rx_cnt[5:0]] = dst_out_data;
                rx_cnt++;
                check(lnk_accept && lnk_valid, "R4 accept/valid with strobe", {lnk_accept, lnk_valid}, 2'b11);
                check(!prev_stb, "R4 strobe width", prev_stb, 0);
            end
            if (lnk_accept && !lnk_valid) rel_cnt++;
            if (prev_acc && !lnk_accept)
                check(rel_cnt >= 1 && rel_cnt <= 4, "R6 accept release delay", rel_cnt, 3);
            if (lnk_accept && lnk_valid) rel_cnt = 0;
            prev_stb = dst_out_strobe;
            prev_acc = lnk_accept;
        end
    end

    task automatic send(input logic [WIDTH-1:0] d, input bit poke);
        int n;
        @(negedge src_clk);
        src_in_valid = 1'b1;
        src_in_data  = d;
        while (!src_in_ready) @(negedge src_clk);
        @(negedge src_clk);
        src_in_valid = 1'b0;
        src_in_data  = ~d;
        check(!lnk_valid && lnk_data == d && !src_in_ready, "R2 word latched, valid low",
              {lnk_valid, src_in_ready, lnk_data}, {2'b00, d});
        @(negedge src_clk);
        check(lnk_valid == 1'b1, "R2 valid one cycle later", lnk_valid, 1);
        check(lnk_data == d, "R3 bus at valid rise", lnk_data, d);
        if (poke) begin
            src_in_valid = 1'b1;
            src_in_data  = 8'hEE;
            @(negedge src_clk);
            @(negedge src_clk);
            src_in_valid = 1'b0;
            check(!src_in_ready && lnk_data == d, "R9 poke ignored on bus", lnk_data, d);
        end
        while (!lnk_accept) begin
            @(negedge src_clk);
            if (!lnk_accept && lnk_data != d)
                check(0, "R3 bus stable", lnk_data, d);
        end
        check(lnk_valid == 1'b1, "R5 valid held until accept seen", lnk_valid, 1);
        n = 0;
        while (lnk_valid && n < 6) begin
            @(negedge src_clk);
            n++;
        end
        check(!lnk_valid && n <= 4, "R5 valid drop delay", n, 3);
        while (!src_in_ready) @(negedge src_clk);
        check(!lnk_accept, "R7 ready only after accept low", lnk_accept, 0);
        sent++;
        check(rx_cnt == sent, "R8 delivery count", rx_cnt, sent);
        check(rx[(sent-1) % 64] == d, "R8 delivered word", rx[(sent-1) % 64], d);
    endtask

    initial begin
        // reset state
        repeat (3) @(negedge src_clk);
        check(!lnk_valid && !lnk_accept && !dst_out_strobe, "R1 wires low in reset",
              {lnk_valid, lnk_accept, dst_out_strobe}, 0);
        src_rst_n = 1'b1;
        @(negedge dst_clk);
        dst_rst_n = 1'b1;
        @(negedge src_clk);
        check(src_in_ready == 1'b1, "R1 ready after reset", src_in_ready, 1);
        check(!lnk_valid && !lnk_accept, "R1 idle after reset", {lnk_valid, lnk_accept}, 0);

        // table walk across receiver speeds
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i][9:8])
                2'd0: dst_half = 3.1;
                2'd1: dst_half = 6.7;
                2'd2: dst_half = 2.3;
                default: dst_half = 11.3;
            endcase
            send(VEC[i][7:0], 1'b0);
        end

        // stray input while busy, slow and fast receivers
        dst_half = 9.7;
        send(8'h5A, 1'b1);
        dst_half = 2.9;
        send(8'h69, 1'b1);
        repeat (30) @(negedge src_clk);
        check(rx_cnt == sent, "R9 no extra word", rx_cnt, sent);
        check(src_in_ready && !lnk_valid, "R9 link idle after poke", {src_in_ready, lnk_valid}, 2'b10);

        // back-to-back words, order preserved
        for (int k = 0; k < 4; k++) send(8'(8'h10 + k), 1'b0);
        for (int k = 0; k < sent; k++)
            if (rx[k] == 8'hEE) check(0, "R9 poke word delivered", rx[k], 0);
        check(rx_cnt == sent, "R8 total delivered", rx_cnt, sent);

        summary();
        $finish;
    end
endmodule